// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps time of day and a calendar in binary-coded decimal. It shows them to software as eight byte-wide registers behind a small synchronous read/write port. A set of internal counters moves forward on a single-cycle pulse that arrives once per second. A separate visible copy of the time is what the port reads and writes. That copy is refreshed from the counters once after every pulse, and all seven time fields change together in one clock edge.

Software uses two bits in the control byte to take a coherent snapshot or to set the clock:

- **Snapshot:** setting the snapshot bit freezes the visible copy while the counters keep running.
- **Setting the clock:** setting the load bit also freezes the copy. Software then writes new time values into the copy, and clearing the load bit moves them into the counters in one edge.

A halt bit in the seconds byte stops timekeeping. A test-enable bit in the weekday byte and a signed trim field in the control byte are stored and read back only; they do not change how the counters run. The read port is combinational from the address.

Top module: `rtcRegFile`

## Requirements
- R1: After reset, the eight offsets read as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, day of month 0x01, month 0x01 and year 0x00. Timekeeping is running and both stored flag bits (halt and test-enable) are clear.
- R2: The register offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month and 7 year. The field widths are:

  | Offset | Register | Field bits | Extra bit |
  |---|---|---|---|
  | 0 | control | all 8 | — |
  | 1 | seconds | [6:0] | bit 7 = halt |
  | 2 | minutes | [6:0] | — |
  | 3 | hours | [5:0] | — |
  | 4 | weekday | [2:0] | bit 6 = test-enable |
  | 5 | day of month | [5:0] | — |
  | 6 | month | [4:0] | — |
  | 7 | year | [7:0] | — |

  Every other bit reads 0, whatever was written to it.
- R3: A tick seen in cycle T advances the counters at the end of T. The visible copy takes the new counter values at the end of T+1, provided neither control bit 7 (load) nor bit 6 (snapshot) was set during T.
- R4: Seconds and minutes wrap from 59 to 00 with a carry. Hours wrap from 23 to 00, and that carry also advances the weekday, which goes 1 to 7 and then back to 1.
- R5: The day of month wraps to 01 after the last day of the month:
  - 30 days for April, June, September and November;
  - 29 days for February when the two-digit year is a multiple of 4, including 00;
  - 28 days for February in all other years;
  - 31 days for every other month.
- R6: When the day of month wraps, the month advances, going from 12 back to 01. When the month wraps, the year advances, going from 99 back to 00.
- R7: While the snapshot bit is 1, ticks leave the visible copy unchanged but the counters keep counting. The first tick after the bit clears shows the up-to-date time.
- R8: Writing the snapshot bit in the same cycle as a tick does not cancel the refresh caused by that tick.
- R9: While the load bit is 1, refreshes are suppressed. A control write that turns the load bit from 1 to 0 copies offsets 1 to 7 into the counters in that edge. A tick in that same cycle is discarded.
- R10: While the halt bit is 1, ticks do not change the counters. Refreshes continue to run, so the visible time stays constant.
- R11: A write to offsets 1 to 7 while both control bits 7 and 6 are 0 is stored and can be read back. The next refresh then replaces it with the counter value. In a cycle where a refresh and such a write coincide, the refresh wins.
- R12: The trim field (control bits 5:0) and the test-enable bit are stored and read back, and they have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oneSecTick | input | 1 | One-cycle pulse, once per second |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset (default width 3) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |

## Verification
The range and date assertions assume the counters only ever hold valid BCD time. That can be false only if software loads invalid digits through the load-bit handshake. The stimulus therefore loads only legal calendar values, and it writes out-of-range bytes only into the visible copy while no load is pending; those bytes are then overwritten by a refresh. A behavioural calendar model in the bench tracks every edge, covering:
- coinciding ticks and control writes;
- month ends for all twelve months;
- leap and non-leap Februaries;
- the last second of year 99.

// File: rtl/rtcPkg.sv
package rtcPkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hours;
    logic [7:0] mins;
    logic [7:0] secs;
  } rtcTime_t;

  typedef struct packed {
    logic advance;
    logic refresh;
    logic load;
  } rtcStrobe_t;

  localparam int REG_CTRL  = 0;
  localparam int REG_SECS  = 1;
  localparam int REG_MINS  = 2;
  localparam int REG_HOURS = 3;
  localparam int REG_WDAY  = 4;
  localparam int REG_MDAY  = 5;
  localparam int REG_MONTH = 6;
  localparam int REG_YEAR  = 7;
  localparam int NUM_REGS  = 8;

  localparam logic [7:0] SECS_MASK  = 8'h7F;
  localparam logic [7:0] MINS_MASK  = 8'h7F;
  localparam logic [7:0] HOURS_MASK = 8'h3F;
  localparam logic [7:0] WDAY_MASK  = 8'h07;
  localparam logic [7:0] MDAY_MASK  = 8'h3F;
  localparam logic [7:0] MONTH_MASK = 8'h1F;
  localparam logic [7:0] YEAR_MASK  = 8'hFF;

  localparam logic [7:0] SECS_LAST  = 8'h59;
  localparam logic [7:0] MINS_LAST  = 8'h59;
  localparam logic [7:0] HOURS_LAST = 8'h23;
  localparam logic [7:0] WDAY_LAST  = 8'h07;
  localparam logic [7:0] MONTH_LAST = 8'h12;
  localparam logic [7:0] YEAR_LAST  = 8'h99;

  localparam int LOAD_BIT = 7;
  localparam int SNAP_BIT = 6;
  localparam int HALT_BIT = 7;
  localparam int TEST_BIT = 6;

  localparam rtcTime_t RESET_TIME = '{
    year: 8'h00, month: 8'h01, mday: 8'h01, wday: 8'h01,
    hours: 8'h00, mins: 8'h00, secs: 8'h00
  };

  // Next BCD value of a two-digit field, no wrap handling.
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Ten mod four equals two, so the tens digit contributes 2*(tens&1).
  function automatic logic isLeapYear(input logic [7:0] year);
    logic [1:0] rem;
    rem = year[1:0] + {year[4], 1'b0};
    return rem == 2'd0;
  endfunction

  function automatic logic [7:0] daysInMonth(input logic [7:0] month,
                                             input logic [7:0] year);
    case (month)
      8'h02:                      return isLeapYear(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcControl.sv
module rtcControl
  import rtcPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oneSecTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              stopBit,
  output logic [7:0]        ctrlReg,
  output rtcStrobe_t        strb
);

  logic ctrlWr;
  logic haltNow;
  logic refreshPend;

  assign ctrlWr  = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign haltNow = ctrlReg[LOAD_BIT] | ctrlReg[SNAP_BIT];

  // Transfer happens only on the 1 -> 0 edge of the load bit.
  assign strb.load    = ctrlWr && ctrlReg[LOAD_BIT] && !wrData[LOAD_BIT];
  assign strb.advance = oneSecTick && !stopBit && !strb.load;
  assign strb.refresh = refreshPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      refreshPend <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= wrData;
      // Halt status sampled before this edge: a halt written now lets a
      // refresh already decided go through.
      refreshPend <= oneSecTick && !haltNow;
    end
  end

endmodule

// File: rtl/rtcCounters.sv
module rtcCounters
  import rtcPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     advance,
  input  logic     load,
  input  rtcTime_t loadTime,
  output rtcTime_t cntTime
);

  rtcTime_t nxtTime;
  logic     secWrap, minWrap, hourWrap, dayWrap, monWrap;

  assign secWrap  = cntTime.secs  == SECS_LAST;
  assign minWrap  = secWrap  && (cntTime.mins  == MINS_LAST);
  assign hourWrap = minWrap  && (cntTime.hours == HOURS_LAST);
  assign dayWrap  = hourWrap && (cntTime.mday  == daysInMonth(cntTime.month, cntTime.year));
  assign monWrap  = dayWrap  && (cntTime.month == MONTH_LAST);

  always_comb begin
    nxtTime      = cntTime;
    nxtTime.secs = secWrap ? 8'h00 : bcdInc(cntTime.secs);
    if (secWrap)
      nxtTime.mins = (cntTime.mins == MINS_LAST) ? 8'h00 : bcdInc(cntTime.mins);
    if (minWrap)
      nxtTime.hours = (cntTime.hours == HOURS_LAST) ? 8'h00 : bcdInc(cntTime.hours);
    if (hourWrap) begin
      nxtTime.wday = (cntTime.wday == WDAY_LAST) ? 8'h01 : bcdInc(cntTime.wday);
      nxtTime.mday = dayWrap ? 8'h01 : bcdInc(cntTime.mday);
    end
    if (dayWrap)
      nxtTime.month = monWrap ? 8'h01 : bcdInc(cntTime.month);
    if (monWrap)
      nxtTime.year = (cntTime.year == YEAR_LAST) ? 8'h00 : bcdInc(cntTime.year);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cntTime <= RESET_TIME;
    else if (load)    cntTime <= loadTime;
    else if (advance) cntTime <= nxtTime;
  end

endmodule

// File: rtl/rtcRegBank.sv
module rtcRegBank
  import rtcPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refresh,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        ctrlReg,
  input  rtcTime_t          cntTime,
  output rtcTime_t          visTime,
  output logic              stopBit,
  output logic [7:0]        rdData
);

  localparam int FIELD_CNT = NUM_REGS - 1;

  logic testBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      visTime <= RESET_TIME;
      stopBit <= 1'b0;
      testBit <= 1'b0;
    end else begin
      if (wrEn && addr == ADDR_W'(REG_SECS)) stopBit <= wrData[HALT_BIT];
      if (wrEn && addr == ADDR_W'(REG_WDAY)) testBit <= wrData[TEST_BIT];
      if (refresh) begin
        visTime <= cntTime;
      end else if (wrEn) begin
        case (addr)
          ADDR_W'(REG_SECS):  visTime.secs  <= wrData & SECS_MASK;
          ADDR_W'(REG_MINS):  visTime.mins  <= wrData & MINS_MASK;
          ADDR_W'(REG_HOURS): visTime.hours <= wrData & HOURS_MASK;
          ADDR_W'(REG_WDAY):  visTime.wday  <= wrData & WDAY_MASK;
          ADDR_W'(REG_MDAY):  visTime.mday  <= wrData & MDAY_MASK;
          ADDR_W'(REG_MONTH): visTime.month <= wrData & MONTH_MASK;
          ADDR_W'(REG_YEAR):  visTime.year  <= wrData & YEAR_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_CTRL):  rdData = ctrlReg;
      ADDR_W'(REG_SECS):  rdData = {stopBit, visTime.secs[6:0]};
      ADDR_W'(REG_MINS):  rdData = visTime.mins;
      ADDR_W'(REG_HOURS): rdData = visTime.hours;
      ADDR_W'(REG_WDAY):  rdData = {1'b0, testBit, 3'b000, visTime.wday[2:0]};
      ADDR_W'(REG_MDAY):  rdData = visTime.mday;
      ADDR_W'(REG_MONTH): rdData = visTime.month;
      ADDR_W'(REG_YEAR):  rdData = visTime.year;
      default:            rdData = (FIELD_CNT > 0) ? 8'h00 : 8'h00;
    endcase
  end

endmodule

// File: rtl/rtcRegFile.sv
module rtcRegFile
  import rtcPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oneSecTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  rtcStrobe_t strb;
  rtcTime_t   cntTime;
  rtcTime_t   visTime;
  logic [7:0] ctrlReg;
  logic       stopBit;

  rtcControl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .oneSecTick(oneSecTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .stopBit(stopBit),
    .ctrlReg(ctrlReg), .strb(strb)
  );

  rtcCounters cnt_i (
    .clk(clk), .rstN(rstN), .advance(strb.advance), .load(strb.load),
    .loadTime(visTime), .cntTime(cntTime)
  );

  rtcRegBank #(.ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rstN(rstN), .refresh(strb.refresh), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .ctrlReg(ctrlReg), .cntTime(cntTime),
    .visTime(visTime), .stopBit(stopBit), .rdData(rdData)
  );

endmodule

// File: rtl/rtcRegFileChecker.sv
module rtcRegFileChecker
  import rtcPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       stopBit,
  input rtcStrobe_t strb,
  input rtcTime_t   cntTime,
  input rtcTime_t   visTime
);

  assert_refresh_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.refresh |=> visTime == $past(cntTime));

  assert_advance_moves_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> cntTime.secs != $past(cntTime.secs));

  assert_frozen_copy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.refresh && !wrEn) |=> visTime == $past(visTime));

  assert_load_transfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> cntTime == $past(visTime));

  assert_halted_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !strb.load) |=> cntTime == $past(cntTime));

  assert_time_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cntTime.secs <= SECS_LAST && cntTime.mins <= MINS_LAST &&
    cntTime.hours <= HOURS_LAST && cntTime.wday != 8'h00 && cntTime.wday <= WDAY_LAST);

  assert_date_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    cntTime.mday != 8'h00 && cntTime.mday <= daysInMonth(cntTime.month, cntTime.year) &&
    cntTime.month != 8'h00 && cntTime.month <= MONTH_LAST);

endmodule

bind rtcRegFile rtcRegFileChecker checker_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .stopBit(stopBit),
  .strb(strb), .cntTime(cntTime), .visTime(visTime)
);

// File: tb/rtcRegFile_test.sv
module rtcRegFile_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oneSecTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  // reference model state (binary counters, byte-wide visible copy)
  int   mCnt[1:7];
  int   mVis[1:7];
  logic [7:0] mCtrl;
  bit   mStop, mFt, mPend;
  int   fieldMask[1:7] = '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  rtcRegFile uut (
    .clk(clk), .rstN(rstN), .oneSecTick(oneSecTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int toBcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int fromBcd(input int b);
    return ((b >> 4) & 15) * 10 + (b & 15);
  endfunction

  function automatic int monthDays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // fields 1..7: sec, min, hour, weekday, date, month, year
  task automatic modelTick();
    mCnt[1]++;
    if (mCnt[1] < 60) return;
    mCnt[1] = 0; mCnt[2]++;
    if (mCnt[2] < 60) return;
    mCnt[2] = 0; mCnt[3]++;
    if (mCnt[3] < 24) return;
    mCnt[3] = 0;
    mCnt[4] = (mCnt[4] == 7) ? 1 : mCnt[4] + 1;
    mCnt[5]++;
    if (mCnt[5] <= monthDays(mCnt[6], mCnt[7])) return;
    mCnt[5] = 1; mCnt[6]++;
    if (mCnt[6] <= 12) return;
    mCnt[6] = 1; mCnt[7] = (mCnt[7] + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '{0, 0, 0, 1, 1, 1, 0};
      for (int i = 1; i <= 7; i++) mVis[i] = toBcd(mCnt[i]);
      mCtrl = 8'h00; mStop = 1'b0; mFt = 1'b0; mPend = 1'b0;
    end else begin
      int   oldVis[1:7];
      logic [7:0] oldCtrl;
      bit   oldStop, oldPend, doLoad;
      oldVis = mVis; oldCtrl = mCtrl; oldStop = mStop; oldPend = mPend;
      doLoad = wrEn && addr == 0 && oldCtrl[7] && !wrData[7];
      if (wrEn && addr == 0) mCtrl = wrData;
      if (wrEn && addr == 1) mStop = wrData[7];
      if (wrEn && addr == 4) mFt = wrData[6];
      if (oldPend) begin
        for (int i = 1; i <= 7; i++) mVis[i] = toBcd(mCnt[i]);
      end else if (wrEn && addr != 0) begin
        mVis[addr] = int'(wrData) & fieldMask[addr];
      end
      mPend = oneSecTick && !(oldCtrl[7] || oldCtrl[6]);
      if (doLoad) begin
        for (int i = 1; i <= 7; i++) mCnt[i] = fromBcd(oldVis[i]);
      end else if (oneSecTick && !oldStop) begin
        modelTick();
      end
    end
  end

  function automatic logic [7:0] modelRead(input int a);
    case (a)
      0:       return mCtrl;
      1:       return {mStop, 7'(mVis[1])};
      4:       return {1'b0, mFt, 3'b000, 3'(mVis[4])};
      default: return 8'(mVis[a]);
    endcase
  endfunction

  // compare the read port against the model every cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] expv;
      expv = modelRead(int'(addr));
      checks++;
      if (rdData !== expv) begin
        fails++;
        $display("FAIL %s offset %0d: got %02h expected %02h", curTag, addr, rdData, expv);
      end
    end
  end

  task automatic cyc(input bit t, input bit w, input int a, input int d);
    @(posedge clk); #1;
    oneSecTick = t; wrEn = w; addr = 3'(a); wrData = 8'(d);
  endtask

  task automatic readAll(input string tag);
    curTag = tag;
    for (int a = 0; a < 8; a++) cyc(1'b0, 1'b0, a, 0);
  endtask

  task automatic loadTime(input int h, input int mi, input int s, input int wd,
                          input int dt, input int mo, input int yr);
    cyc(0, 1, 0, 8'h80);
    cyc(0, 1, 1, s);  cyc(0, 1, 2, mi); cyc(0, 1, 3, h);
    cyc(0, 1, 4, wd); cyc(0, 1, 5, dt); cyc(0, 1, 6, mo); cyc(0, 1, 7, yr);
    cyc(0, 1, 0, 8'h00);
    cyc(0, 0, 0, 0);
  endtask

  task automatic tickAndRead(input string tag);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    readAll(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset contents
    readAll("R1");

    // R2: unused bits masked; R11: plain writes stored, then replaced
    curTag = "R2";
    cyc(0, 1, 2, 8'hFF); cyc(0, 1, 3, 8'hFF); cyc(0, 1, 5, 8'hFF);
    cyc(0, 1, 6, 8'hFF); cyc(0, 1, 7, 8'hA5);
    readAll("R2");
    tickAndRead("R11");

    // R3: several ticks with different spacing
    curTag = "R3";
    cyc(1, 0, 1, 0); cyc(0, 0, 1, 0); cyc(1, 0, 1, 0); cyc(1, 0, 1, 0);
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    readAll("R3");

    // R4: wraps of seconds, minutes, hours, weekday 7 -> 1
    loadTime(8'h23, 8'h59, 8'h59, 8'h07, 8'h10, 8'h05, 8'h23);
    tickAndRead("R4");
    loadTime(8'h12, 8'h58, 8'h30, 8'h03, 8'h10, 8'h05, 8'h23);
    curTag = "R4";
    repeat (100) cyc(1, 0, 2, 0);
    readAll("R4");

    // R5: last day of every month, plus leap and non-leap February
    for (int m = 1; m <= 12; m++) begin
      loadTime(8'h23, 8'h59, 8'h59, 8'h02, toBcd(monthDays(m, 23)), toBcd(m), 8'h23);
      tickAndRead("R5");
    end
    loadTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    tickAndRead("R5");
    tickAndRead("R5");
    loadTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h00);
    tickAndRead("R5");
    loadTime(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h98);
    tickAndRead("R5");

    // R6: end of year 99
    loadTime(8'h23, 8'h59, 8'h59, 8'h06, 8'h31, 8'h12, 8'h99);
    tickAndRead("R6");

    // R7: snapshot freezes the copy, counters continue
    loadTime(8'h08, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
    cyc(0, 1, 0, 8'h40);
    curTag = "R7";
    repeat (5) begin cyc(1, 0, 1, 0); cyc(0, 0, 1, 0); end
    readAll("R7");
    cyc(0, 1, 0, 8'h00);
    tickAndRead("R7");

    // R8: snapshot set in the tick cycle still lets that refresh through
    cyc(1, 1, 0, 8'h40);
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
    readAll("R8");
    cyc(0, 1, 0, 8'h00);

    // R9: tick coinciding with the load-bit clear is dropped
    cyc(0, 1, 0, 8'h80);
    cyc(0, 1, 1, 8'h45); cyc(0, 1, 2, 8'h30); cyc(0, 1, 3, 8'h11);
    curTag = "R9";
    cyc(1, 0, 1, 0); cyc(0, 0, 1, 0);
    cyc(1, 1, 0, 8'h00);
    cyc(0, 0, 1, 0);
    tickAndRead("R9");

    // R10: halt bit stops counting
    cyc(0, 1, 1, 8'h80 | 8'h20);
    curTag = "R10";
    repeat (6) begin cyc(1, 0, 1, 0); cyc(0, 0, 1, 0); end
    readAll("R10");
    cyc(0, 1, 1, 8'h20);
    tickAndRead("R10");

    // R11: plain write collides with a refresh cycle
    cyc(1, 0, 2, 0);
    cyc(0, 1, 2, 8'h44);
    cyc(0, 0, 2, 0);
    readAll("R11");

    // R12: trim and test-enable stored, counting unaffected
    cyc(0, 1, 0, 8'h3F);
    cyc(0, 1, 4, 8'h45);
    readAll("R12");
    cyc(0, 1, 0, 8'h1A);
    curTag = "R12";
    repeat (70) cyc(1, 0, 1, 0);
    readAll("R12");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule